// File: doc/BRIEF.md
# Periodic Coprocessor Wakeup Sequencer

This block sets the duty cycle of a low-power coprocessor. A sleep timer counts strobes of a slow clock up to a programmed period. When the period is reached, the sequencer asks for power, waits for the power switch to acknowledge, and then releases the coprocessor core to run from a configured start address. The sequencer then waits for the program to stop. A program stops in one of three ways: it writes a done flag, it raises a trap, or the host halts it. After the stop, the sequencer drops the core, asks for power-off, waits for the acknowledge to fall, and restarts the timer from zero. It re-arms only if the timer is still enabled.

A small write-only host port sets the period, the start address and the timer enable. The same port issues stop, resume, halt and reset commands. A trap disarms the timer and raises a one-cycle wake request to the main CPU. The sequencer keeps a halt-cause code that tells a trap apart from a normal done or a host halt. The processor core, the power switch and the oscillator lie outside the block. The block connects to them through level and pulse ports.

Top module: `wake_seq_top`

## Requirements
- R1: After the synchronous reset `rst`, `pwr_req`, `cp_run` and `wake_req` are 0, `halt_cause` is 0 and the timer is disabled.
- R2: Once enabled, the sequencer raises `pwr_req` on exactly the P-th `slow_tick` strobe, where P is the latched period. A period of 0 behaves as 1. `cp_run` rises only after `pwr_ack` has been seen high. While `cp_run` is high, `cp_entry` shows the start address.
- R3: `cp_done` while running drops `cp_run` and `pwr_req`. It sets `halt_cause` to 2'b01 and raises no wake request. When `pwr_ack` falls, the count restarts from zero and the next run follows after another P strobes.
- R4: `cp_trap` while running sets `halt_cause` to 2'b10, pulses `wake_req` for exactly one cycle and clears the timer enable, so no further run follows. If `cp_trap` and `cp_done` arrive in the same cycle, the trap wins.
- R5: A stop command (host address 3, bit 0) or a write of 0 to the control register (address 2, bit 0) does not end a running program. After that program halts, no further run starts.
- R6: Asserting `cp_en_clr` while the program runs clears the timer enable. The current run continues, and no new run follows.
- R7: A resume command (address 3, bit 1) sets the enable again and keeps the stored period and start address.
- R8: A halt command (address 3, bit 2) while running stops the program with `halt_cause` 2'b11. If the timer is still enabled, the next run follows after P more strobes.
- R9: A reset command (address 3, bit 3) returns the sequencer to idle from any state within one cycle. It drops `cp_run` and `pwr_req`, sets `halt_cause` to 0 and clears the enable. The period and start address are kept.
- R10: A period written at address 0 while the timer counts takes effect only at the next restart of the count.
- R11: `cp_done`, `cp_trap` and `cp_en_clr` have no effect unless the program is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock tick |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | 0 period, 1 start address, 2 control, 3 command |
| host_wdata | input | DATA_W | Host write data |
| pwr_req | output | 1 | Request power for the coprocessor |
| pwr_ack | input | 1 | Power switch state, high when the supply is good |
| cp_run | output | 1 | Releases the core from reset |
| cp_entry | output | ENTRY_W | Start address latched for the current run |
| cp_done | input | 1 | Program-written done flag |
| cp_trap | input | 1 | Trap from an illegal processor state |
| cp_en_clr | input | 1 | Coprocessor request to clear the timer enable |
| wake_req | output | 1 | One-cycle wake pulse to the main CPU on a trap |
| halt_cause | output | 2 | Last stop: 01 done, 10 trap, 11 host halt, 00 none |

## Verification
The scoreboard follows several run cycles and records each power-up, start address, stop cause and wake pulse as an ordered event. Each stop path is tried:
- A plain done shows that restarting from zero and re-arming are correct.
- A host halt separates its cause code from done.
- A trap arriving together with done shows the priority rule, the single wake pulse and the disarm.

Tick patterns one strobe short of the period, and one strobe past it, pin down the expiry cycle. The patterns cover the period of 0 and a period rewritten in the middle of a count. Stop, enable clearing by the coprocessor, and flags pulsed during power-up and idle are each followed by strobes with no power-up. This shows that those inputs do not abort a run and do not cause a new one.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_COUNT = 3'd1,
        ST_PWRUP = 3'd2,
        ST_RUN   = 3'd3,
        ST_PWRDN = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_DONE = 2'b01,
        CAUSE_TRAP = 2'b10,
        CAUSE_HOST = 2'b11
    } halt_cause_t;

    localparam logic [1:0] A_PERIOD = 2'd0;
    localparam logic [1:0] A_ENTRY  = 2'd1;
    localparam logic [1:0] A_CTRL   = 2'd2;
    localparam logic [1:0] A_CMD    = 2'd3;

    localparam int CMD_STOP_BIT   = 0;
    localparam int CMD_RESUME_BIT = 1;
    localparam int CMD_HALT_BIT   = 2;
    localparam int CMD_RESET_BIT  = 3;

    typedef struct packed {
        logic stop;
        logic resume;
        logic halt;
        logic reset;
    } host_cmd_t;

    function automatic host_cmd_t decode_cmd(input logic we, input logic [1:0] addr,
                                             input logic [3:0] bits);
        host_cmd_t c;
        logic      hit;
        hit      = we && (addr == A_CMD);
        c.stop   = hit && bits[CMD_STOP_BIT];
        c.resume = hit && bits[CMD_RESUME_BIT];
        c.halt   = hit && bits[CMD_HALT_BIT];
        c.reset  = hit && bits[CMD_RESET_BIT];
        return c;
    endfunction

    // Stop source priority while running: trap, then done, then host halt.
    function automatic halt_cause_t pick_cause(input logic trap, input logic done,
                                               input logic halt);
        if (trap)      return CAUSE_TRAP;
        else if (done) return CAUSE_DONE;
        else if (halt) return CAUSE_HOST;
        else           return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/wake_seq_regs.sv
module wake_seq_regs
    import wake_seq_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int ENTRY_W  = 16,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_we,
    input  logic [1:0]          host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic                trap_disarm,
    input  logic                cp_disarm,
    output logic [PERIOD_W-1:0] period_q,
    output logic [ENTRY_W-1:0]  entry_q,
    output logic                enable_q,
    output host_cmd_t           cmd
);

    localparam int CMD_W = 4;

    logic enable_d;
    logic wr_period, wr_entry, wr_ctrl;
    logic unused_wdata;

    assign unused_wdata = ^host_wdata;

    assign cmd       = decode_cmd(host_we, host_addr, host_wdata[CMD_W-1:0]);
    assign wr_period = host_we && (host_addr == A_PERIOD);
    assign wr_entry  = host_we && (host_addr == A_ENTRY);
    assign wr_ctrl   = host_we && (host_addr == A_CTRL);

    // Clears win over sets.
    always_comb begin
        enable_d = enable_q;
        if (wr_ctrl)    enable_d = host_wdata[0];
        if (cmd.resume) enable_d = 1'b1;
        if (cmd.stop || cmd.reset || trap_disarm || cp_disarm) enable_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            entry_q  <= '0;
            enable_q <= 1'b0;
        end else begin
            enable_q <= enable_d;
            if (wr_period) period_q <= host_wdata[PERIOD_W-1:0];
            if (wr_entry)  entry_q  <= host_wdata[ENTRY_W-1:0];
        end
    end

    AST_TRAP_DISARMS: assert property (@(posedge clk) disable iff (rst)
        trap_disarm |=> !enable_q) else $error("trap left timer armed"); // R4
    AST_COP_DISARMS: assert property (@(posedge clk) disable iff (rst)
        cp_disarm |=> !enable_q) else $error("coprocessor clear ignored"); // R6
    AST_RESUME_KEEPS_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (cmd.resume && !wr_period) |=> $stable(period_q)) else $error("resume changed period"); // R7

endmodule

// File: rtl/wake_seq_timer.sv
module wake_seq_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                run,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] period_in,
    output logic                expire
);

    logic [PERIOD_W-1:0] count_q;
    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W:0]   count_nx;

    assign count_nx = {1'b0, count_q} + 1'b1;
    // A zero period expires on the first strobe.
    assign expire   = run && tick && (count_nx >= {1'b0, period_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            period_q <= '0;
        end else if (restart) begin
            count_q  <= '0;
            period_q <= period_in;
        end else if (run && tick && !expire) begin
            count_q  <= count_nx[PERIOD_W-1:0];
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (count_q < period_q) || (count_q == '0)) else $error("count passed period"); // R2
    AST_PERIOD_LATCHED: assert property (@(posedge clk) disable iff (rst)
        !restart |=> $stable(period_q)) else $error("period changed mid count"); // R10

endmodule

// File: rtl/wake_seq_fsm.sv
module wake_seq_fsm
    import wake_seq_pkg::*;
#(
    parameter int ENTRY_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               expire,
    input  logic               pwr_ack,
    input  logic               cp_done,
    input  logic               cp_trap,
    input  logic               cp_en_clr,
    input  logic               host_halt,
    input  logic               host_reset,
    input  logic [ENTRY_W-1:0] entry_in,
    output logic               restart,
    output logic               timer_run,
    output logic               trap_disarm,
    output logic               cp_disarm,
    output logic               pwr_req,
    output logic               cp_run,
    output logic [ENTRY_W-1:0] cp_entry,
    output logic               wake_req,
    output logic [1:0]         halt_cause
);

    seq_state_t  state_q, state_d;
    halt_cause_t cause_q, cause_d;
    halt_cause_t stop_src;
    logic        stop_now;
    logic        wake_d;
    logic [ENTRY_W-1:0] entry_run_q;

    assign stop_src = pick_cause(cp_trap, cp_done, host_halt);
    assign stop_now = (state_q == ST_RUN) && (stop_src != CAUSE_NONE) && !host_reset;

    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        wake_d  = 1'b0;
        restart = 1'b0;
        if (host_reset) begin
            state_d = ST_IDLE;
            cause_d = CAUSE_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (enable && !pwr_ack) begin
                        state_d = ST_COUNT;
                        restart = 1'b1;
                    end
                end
                ST_COUNT: begin
                    if (!enable)     state_d = ST_IDLE;
                    else if (expire) state_d = ST_PWRUP;
                end
                ST_PWRUP: begin
                    if (pwr_ack) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (stop_now) begin
                        state_d = ST_PWRDN;
                        cause_d = stop_src;
                        wake_d  = (stop_src == CAUSE_TRAP);
                    end
                end
                ST_PWRDN: begin
                    if (!pwr_ack) begin
                        if (enable) begin
                            state_d = ST_COUNT;
                            restart = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign trap_disarm = stop_now && (stop_src == CAUSE_TRAP);
    assign cp_disarm   = (state_q == ST_RUN) && cp_en_clr;
    assign timer_run   = (state_q == ST_COUNT);
    assign pwr_req     = (state_q == ST_PWRUP) || (state_q == ST_RUN);
    assign cp_run      = (state_q == ST_RUN);
    assign cp_entry    = entry_run_q;
    assign halt_cause  = cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cause_q     <= CAUSE_NONE;
            wake_req    <= 1'b0;
            entry_run_q <= '0;
        end else begin
            state_q  <= state_d;
            cause_q  <= cause_d;
            wake_req <= wake_d;
            if (state_q == ST_PWRUP && state_d == ST_RUN) entry_run_q <= entry_in;
        end
    end

    AST_RUN_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(cp_run) |-> $past(pwr_ack)) else $error("run before power good"); // R2
    AST_WAKE_FROM_TRAP: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> $past(state_q == ST_RUN && cp_trap)) else $error("wake without trap"); // R4
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !wake_req) else $error("wake longer than one cycle"); // R4
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !cp_done && !cp_trap && !host_halt && !host_reset)
        |=> (state_q == ST_RUN)) else $error("run ended without stop source"); // R5
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        host_reset |=> (state_q == ST_IDLE && !pwr_req)) else $error("reset command ignored"); // R9

endmodule

// File: rtl/wake_seq_top.sv
module wake_seq_top
    import wake_seq_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int ENTRY_W  = 16,
    parameter int DATA_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slow_tick,
    input  logic               host_we,
    input  logic [1:0]         host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic               pwr_req,
    input  logic               pwr_ack,
    output logic               cp_run,
    output logic [ENTRY_W-1:0] cp_entry,
    input  logic               cp_done,
    input  logic               cp_trap,
    input  logic               cp_en_clr,
    output logic               wake_req,
    output logic [1:0]         halt_cause
);

    logic [PERIOD_W-1:0] period_q;
    logic [ENTRY_W-1:0]  entry_q;
    logic                enable_q;
    host_cmd_t           cmd;
    logic                restart, timer_run, expire;
    logic                trap_disarm, cp_disarm;

    wake_seq_regs #(.PERIOD_W(PERIOD_W), .ENTRY_W(ENTRY_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .trap_disarm(trap_disarm), .cp_disarm(cp_disarm),
        .period_q(period_q), .entry_q(entry_q), .enable_q(enable_q), .cmd(cmd)
    );

    wake_seq_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk(clk), .rst(rst), .restart(restart), .run(timer_run),
        .tick(slow_tick), .period_in(period_q), .expire(expire)
    );

    wake_seq_fsm #(.ENTRY_W(ENTRY_W)) u_fsm (
        .clk(clk), .rst(rst), .enable(enable_q), .expire(expire), .pwr_ack(pwr_ack),
        .cp_done(cp_done), .cp_trap(cp_trap), .cp_en_clr(cp_en_clr),
        .host_halt(cmd.halt), .host_reset(cmd.reset), .entry_in(entry_q),
        .restart(restart), .timer_run(timer_run), .trap_disarm(trap_disarm),
        .cp_disarm(cp_disarm), .pwr_req(pwr_req), .cp_run(cp_run),
        .cp_entry(cp_entry), .wake_req(wake_req), .halt_cause(halt_cause)
    );

endmodule

// File: tb/test_wake_seq_top.sv
`timescale 1ns/1ps
module test_wake_seq_top;

    localparam int PW = 16;
    localparam int EW = 16;
    localparam int DW = 32;
    localparam int EV_PUP = 0, EV_RUN = 1, EV_HALT = 2, EV_WAKE = 3;

    typedef struct { int kind; int data; string tag; } exp_ev_t;

    logic clk = 1'b0, rst = 1'b1, slow_tick = 1'b0, host_we = 1'b0;
    logic [1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic pwr_req, pwr_ack = 1'b0, ack_d = 1'b0;
    logic cp_run, cp_done = 1'b0, cp_trap = 1'b0, cp_en_clr = 1'b0;
    logic [EW-1:0] cp_entry;
    logic wake_req;
    logic [1:0] halt_cause;

    int checks = 0, failures = 0;
    bit finished = 0;
    exp_ev_t sb[$];

    always #10 clk = ~clk;

    wake_seq_top #(.PERIOD_W(PW), .ENTRY_W(EW), .DATA_W(DW)) i_wake_seq_top (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .pwr_req(pwr_req),
        .pwr_ack(pwr_ack), .cp_run(cp_run), .cp_entry(cp_entry), .cp_done(cp_done),
        .cp_trap(cp_trap), .cp_en_clr(cp_en_clr), .wake_req(wake_req),
        .halt_cause(halt_cause)
    );

    // Power switch model: acknowledge follows the request two edges later.
    initial forever begin
        @(posedge clk);
        ack_d   <= pwr_req;
        pwr_ack <= ack_d;
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_ev(int kind, int data, string tag);
        exp_ev_t e;
        e.kind = kind; e.data = data; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: turns output edges into events and pops the scoreboard.
    task automatic observe(int kind, int data);
        exp_ev_t e;
        checks++;
        if (sb.size() == 0) begin
            failures++;
            $display("FAIL unexpected-event actual=%0d:%0h expected=none", kind, data);
        end else begin
            e = sb.pop_front();
            if (e.kind != kind || e.data != data) begin
                failures++;
                $display("FAIL %s actual=%0d:%0h expected=%0d:%0h", e.tag, kind, data, e.kind, e.data);
            end
        end
    endtask

    initial begin
        logic p_pwr, p_run;
        p_pwr = 1'b0; p_run = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (pwr_req && !p_pwr) observe(EV_PUP, 0);
                if (cp_run && !p_run)  observe(EV_RUN, int'(cp_entry));
                if (!cp_run && p_run)  observe(EV_HALT, int'(halt_cause));
                if (wake_req)          observe(EV_WAKE, int'(halt_cause));
            end
            p_pwr = pwr_req; p_run = cp_run;
        end
    end

    task automatic host_write(logic [1:0] a, int d);
        host_we = 1'b1; host_addr = a; host_wdata = DW'(d);
        @(posedge clk); @(negedge clk);
        host_we = 1'b0; host_wdata = '0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            slow_tick = 1'b1;
            @(posedge clk); @(negedge clk);
            slow_tick = 1'b0;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done(logic d, logic t);
        cp_done = d; cp_trap = t;
        @(posedge clk); @(negedge clk);
        cp_done = 1'b0; cp_trap = 1'b0;
    endtask

    task automatic wait_run(string tag);
        int n = 0;
        while (!cp_run && n < 20) begin @(negedge clk); n++; end
        check(tag, int'(cp_run), 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        check("R1 pwr_req", int'(pwr_req), 0);
        check("R1 cp_run", int'(cp_run), 0);
        check("R1 wake_req", int'(wake_req), 0);
        check("R1 halt_cause", int'(halt_cause), 0);
        ticks(4);
        check("R1 disabled after reset", int'(pwr_req), 0);

        // R2 expiry on the fifth strobe, run after ack at the start address
        host_write(2'd0, 5);
        host_write(2'd1, 'h120);
        host_write(2'd2, 1);
        idle(3);
        expect_ev(EV_PUP, 0, "R2 power-up");
        expect_ev(EV_RUN, 'h120, "R2 start address");
        ticks(4);
        check("R2 no power-up before period", int'(pwr_req), 0);
        ticks(1);
        check("R2 power-up at period", int'(pwr_req), 1);
        check("R2 run waits for ack", int'(cp_run), 0);
        pulse_done(1'b1, 1'b1); // R11 flags during power-up are ignored
        wait_run("R2 run after ack");
        idle(3);
        check("R11 still running", int'(cp_run), 1);
        check("R11 no wake from early trap", int'(wake_req), 0);

        // R3 done path: no wake, restart from zero
        expect_ev(EV_HALT, 1, "R3 done cause");
        pulse_done(1'b1, 1'b0);
        check("R3 run dropped", int'(cp_run), 0);
        check("R3 no wake on done", int'(wake_req), 0);
        idle(5);
        expect_ev(EV_PUP, 0, "R3 re-arm power-up");
        expect_ev(EV_RUN, 'h120, "R3 re-arm run");
        ticks(4);
        check("R3 count restarted", int'(pwr_req), 0);
        ticks(1);
        check("R3 re-armed after period", int'(pwr_req), 1);
        wait_run("R3 second run");

        // R8 host halt, then R10 period rewrite during count
        expect_ev(EV_HALT, 3, "R8 host halt cause");
        host_write(2'd3, 4);
        check("R8 halted", int'(cp_run), 0);
        idle(5);
        host_write(2'd0, 3);
        expect_ev(EV_PUP, 0, "R10 power-up on old period");
        expect_ev(EV_RUN, 'h120, "R8 rerun");
        ticks(4);
        check("R10 new period not used mid count", int'(pwr_req), 0);
        ticks(1);
        check("R10 old period completes", int'(pwr_req), 1);
        wait_run("R8 rerun after halt");

        // R5 stop does not abort, and blocks future runs
        host_write(2'd3, 1);
        idle(4);
        check("R5 stop keeps program running", int'(cp_run), 1);
        expect_ev(EV_HALT, 1, "R5 done after stop");
        pulse_done(1'b1, 1'b0);
        idle(6);
        ticks(6);
        check("R5 no run after stop", int'(pwr_req), 0);

        // R7 resume keeps period 3
        host_write(2'd3, 2);
        idle(3);
        expect_ev(EV_PUP, 0, "R7 power-up");
        expect_ev(EV_RUN, 'h120, "R7 run");
        ticks(2);
        check("R7 period kept (early)", int'(pwr_req), 0);
        ticks(1);
        check("R7 period kept", int'(pwr_req), 1);
        wait_run("R7 run after resume");

        // R6 coprocessor clears enable
        cp_en_clr = 1'b1; @(posedge clk); @(negedge clk); cp_en_clr = 1'b0;
        idle(2);
        check("R6 run continues", int'(cp_run), 1);
        expect_ev(EV_HALT, 1, "R6 done");
        pulse_done(1'b1, 1'b0);
        idle(6);
        ticks(5);
        check("R6 no further run", int'(pwr_req), 0);

        // R4 trap with done in the same cycle
        host_write(2'd2, 1);
        idle(3);
        expect_ev(EV_PUP, 0, "R4 power-up");
        expect_ev(EV_RUN, 'h120, "R4 run");
        ticks(3);
        wait_run("R4 run");
        expect_ev(EV_HALT, 2, "R4 trap cause");
        expect_ev(EV_WAKE, 2, "R4 wake");
        pulse_done(1'b1, 1'b1);
        check("R4 wake raised", int'(wake_req), 1);
        check("R4 trap beats done", int'(halt_cause), 2);
        idle(1);
        check("R4 wake one cycle", int'(wake_req), 0);
        idle(5);
        pulse_done(1'b0, 1'b1); // R11 trap in idle ignored
        cp_en_clr = 1'b1; idle(1); cp_en_clr = 1'b0;
        check("R11 no wake from idle trap", int'(wake_req), 0);
        ticks(5);
        check("R4 timer disarmed", int'(pwr_req), 0);

        // R2 zero period expires on first strobe
        host_write(2'd0, 0);
        host_write(2'd2, 1);
        idle(3);
        expect_ev(EV_PUP, 0, "R2 zero period");
        expect_ev(EV_RUN, 'h120, "R2 zero period run");
        ticks(1);
        check("R2 zero period acts as one", int'(pwr_req), 1);
        wait_run("R2 zero period run");

        // R9 reset command from run
        expect_ev(EV_HALT, 0, "R9 reset cause");
        host_write(2'd3, 8);
        check("R9 run dropped", int'(cp_run), 0);
        check("R9 power dropped", int'(pwr_req), 0);
        idle(4);
        ticks(3);
        check("R9 enable cleared", int'(pwr_req), 0);
        host_write(2'd3, 2);
        idle(4);
        expect_ev(EV_PUP, 0, "R9 period kept");
        expect_ev(EV_RUN, 'h120, "R9 entry kept");
        ticks(1);
        check("R9 period retained", int'(pwr_req), 1);
        wait_run("R9 run after reset");
        expect_ev(EV_HALT, 0, "R9 final reset");
        host_write(2'd3, 8);
        idle(4);
        check("scoreboard drained", sb.size(), 0);
        finish_run();
    end

endmodule